// File: doc/BRIEF.md
# EEPROM Page Commit Protection Controller

This block stands between a 32-byte staging buffer and a byte-wide non-volatile array. The array's address space holds 80 data pages, a register page and a read-only factory page. When a commit request arrives with a target address, the block takes a snapshot of the protection policy that applies to that page. It then walks the 32 byte positions in order, one per clock. For each position it presents the read address, takes back the byte currently stored there and the staging byte for the same position, and issues a write strobe with the byte to be programmed. A commit that the policy forbids gets a single abort pulse and no walk.

The data pages fall into ten groups of eight pages. Each group is governed by a code byte in the register page. Two further register-page bytes act as lock bytes: one turns write-protected groups into commit-refused groups, and the other seals the register page itself. The block keeps shadow copies of all twelve policy bytes and refreshes them from its own committed writes. The array, its programming delay and the serial command layer that issues requests are handled elsewhere.

Top module: `eeprom_guard`

## Requirements
- R1: After reset, wr_en_o, abort_o, done_o and busy_o are 0, and every group is unprotected, so a first commit to any data page writes the staging bytes.
- R2: An accepted commit drives busy_o high from the cycle after the request. It writes positions 0 to 31 at consecutive addresses on consecutive cycles, the first write one cycle after busy_o rises. done_o pulses together with the write of position 31, and busy_o falls in that same cycle.
- R3: The group of a data address is address bits [11:8], and the code byte of group n sits at address 0xA00+n. Any code other than 0x55 or 0xAA leaves the group unprotected, and each staging byte is written unchanged.
- R4: For a group whose code is 0x55 (write protected) with no group lock, the commit runs and each write carries the byte already stored, so the data does not change.
- R5: For a group whose code is 0xAA (one-way mode), each written byte is the bitwise AND of the stored byte and the staging byte.
- R6: When the byte at 0xA1E holds 0x55 or 0xAA, a commit to a 0x55 group pulses abort_o once, the cycle after the request, and makes no write. Groups with code 0xAA still commit.
- R7: When the byte at 0xA1F holds 0x55 or 0xAA, a commit to the register page (0xA00 to 0xA1F) is aborted, including its general-purpose bytes at 0xA0A to 0xA1D.
- R8: In a register-page commit, any of the bytes 0xA00 to 0xA09, 0xA1E and 0xA1F that already holds 0x55 or 0xAA is rewritten with its stored value. All other register-page bytes take the staging byte.
- R9: A commit to the factory page (0xA20 to 0xA3F) walks all 32 cycles and pulses done_o, and never asserts wr_en_o.
- R10: A commit to any address at or above 0xA40 is aborted.
- R11: Policy bytes written by a commit govern later commits. The policy for a commit is fixed when it is requested.
- R12: Address bits [4:0] of the request are ignored (the walk starts at the page base), and a request made while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Commit request, one cycle |
| tgt_addr_i | input | 12 | Commit target address |
| rd_addr_o | output | 12 | Address of the byte position being walked |
| stored_i | input | 8 | Byte currently stored at rd_addr_o |
| pad_i | input | 8 | Staging byte for position rd_addr_o[4:0] |
| wr_en_o | output | 1 | Write strobe |
| wr_addr_o | output | 12 | Write address |
| wr_data_o | output | 8 | Byte to program |
| abort_o | output | 1 | Commit refused, one-cycle pulse |
| done_o | output | 1 | Walk finished, one-cycle pulse |
| busy_o | output | 1 | Walk in progress |

## Verification
On every cycle the assertions check the shape of the output stream. Writes within a walk come at consecutive addresses. No write ever targets the factory page. An abort comes only one cycle after an idle-time request, and never together with a write or a walk. done_o closes a walk. Whether a given policy byte value yields the stored byte, the AND or the staging byte depends on the array contents and the shadowed policy, and only the bench's scenarios can show this. The same goes for whether a lock byte escalates protection, for self-sealing of policy bytes, and for the ignoring of requests made mid-walk. The bench compares every cycle against a behavioural model of the array.

// File: rtl/eg_pkg.sv
package eg_pkg;

    localparam logic [7:0] CODE_A = 8'h55;
    localparam logic [7:0] CODE_B = 8'hAA;

    typedef enum logic [2:0] {
        MD_OPEN,
        MD_WRPROT,
        MD_ONEWAY,
        MD_REGPG,
        MD_ROPAGE
    } mode_t;

    function automatic logic is_sealed(input logic [7:0] c);
        return (c == CODE_A) || (c == CODE_B);
    endfunction

endpackage

// File: rtl/eg_shadow.sv
module eg_shadow #(
    parameter int AW      = 12,
    parameter int NBLK    = 10,
    parameter int REG_A   = 'hA00,
    parameter int PG_BYTES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic [7:0]           wdata,
    output logic [NBLK-1:0][7:0] codes,
    output logic                 grp_lock,
    output logic                 pg_lock
);
    localparam logic [AW-1:0] GLOCK_A = AW'(REG_A + PG_BYTES - 2);
    localparam logic [AW-1:0] PLOCK_A = AW'(REG_A + PG_BYTES - 1);

    logic [7:0] glock_q, plock_q;

    for (genvar i = 0; i < NBLK; i++) begin : g_code
        logic [7:0] code_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                code_q <= '0;
            else if (we && waddr == AW'(REG_A + i))
                code_q <= wdata;
        end
        assign codes[i] = code_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glock_q <= '0;
            plock_q <= '0;
        end else if (we) begin
            if (waddr == GLOCK_A) glock_q <= wdata;
            if (waddr == PLOCK_A) plock_q <= wdata;
        end
    end

    assign grp_lock = eg_pkg::is_sealed(glock_q);
    assign pg_lock  = eg_pkg::is_sealed(plock_q);
endmodule

// File: rtl/eg_policy.sv
module eg_policy #(
    parameter int AW        = 12,
    parameter int NBLK      = 10,
    parameter int BLK_SHIFT = 8,
    parameter int REG_A     = 'hA00,
    parameter int PG_BYTES  = 32
) (
    input  logic [AW-1:0]        addr,
    input  logic [NBLK-1:0][7:0] codes,
    input  logic                 grp_lock,
    input  logic                 pg_lock,
    output eg_pkg::mode_t        mode,
    output logic                 refuse
);
    import eg_pkg::*;

    localparam logic [AW-1:0] REG_LO = AW'(REG_A);
    localparam logic [AW-1:0] ROM_LO = AW'(REG_A + PG_BYTES);
    localparam logic [AW-1:0] END_LO = AW'(REG_A + 2 * PG_BYTES);

    logic [AW-BLK_SHIFT-1:0] grp;
    logic [7:0]              code;

    assign grp  = addr[AW-1:BLK_SHIFT];
    assign code = codes[grp];

    always_comb begin
        mode   = MD_OPEN;
        refuse = 1'b0;
        if (addr >= END_LO) begin
            refuse = 1'b1;
        end else if (addr >= ROM_LO) begin
            mode = MD_ROPAGE;
        end else if (addr >= REG_LO) begin
            mode   = MD_REGPG;
            refuse = pg_lock;
        end else if (code == CODE_A) begin
            mode   = MD_WRPROT;
            refuse = grp_lock;
        end else if (code == CODE_B) begin
            mode = MD_ONEWAY;
        end
    end
endmodule

// File: rtl/eeprom_guard.sv
module eeprom_guard #(
    parameter int AW        = 12,
    parameter int PG_BYTES  = 32,
    parameter int BLK_PAGES = 8,
    parameter int NBLK      = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [AW-1:0] tgt_addr_i,
    output logic [AW-1:0] rd_addr_o,
    input  logic [7:0]    stored_i,
    input  logic [7:0]    pad_i,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [7:0]    wr_data_o,
    output logic          abort_o,
    output logic          done_o,
    output logic          busy_o
);
    import eg_pkg::*;

    localparam int PW        = $clog2(PG_BYTES);
    localparam int BLK_BYTES = BLK_PAGES * PG_BYTES;
    localparam int BLK_SHIFT = $clog2(BLK_BYTES);
    localparam int REG_A     = NBLK * BLK_BYTES;
    localparam logic [AW-1:0] CODE_LO = AW'(REG_A);
    localparam logic [AW-1:0] CODE_HI = AW'(REG_A + NBLK);
    localparam logic [AW-1:0] GLOCK_A = AW'(REG_A + PG_BYTES - 2);
    localparam logic [AW-1:0] PLOCK_A = AW'(REG_A + PG_BYTES - 1);

    typedef struct packed {
        logic          busy;
        logic [PW-1:0] pos;
        logic [AW-1:0] base;
        mode_t         mode;
        logic          wr_en;
        logic [AW-1:0] wr_addr;
        logic [7:0]    wr_data;
        logic          abort;
        logic          done;
    } st_t;

    st_t q, d;

    logic [NBLK-1:0][7:0] codes;
    logic                 grp_lock, pg_lock, refuse, self_sealed;
    mode_t                req_mode;
    logic [AW-1:0]        cur_addr;

    eg_shadow #(.AW(AW), .NBLK(NBLK), .REG_A(REG_A), .PG_BYTES(PG_BYTES)) u_shadow (
        .clk(clk), .rst_n(rst_n),
        .we(d.wr_en), .waddr(d.wr_addr), .wdata(d.wr_data),
        .codes(codes), .grp_lock(grp_lock), .pg_lock(pg_lock)
    );

    eg_policy #(.AW(AW), .NBLK(NBLK), .BLK_SHIFT(BLK_SHIFT), .REG_A(REG_A),
                .PG_BYTES(PG_BYTES)) u_policy (
        .addr(tgt_addr_i), .codes(codes), .grp_lock(grp_lock), .pg_lock(pg_lock),
        .mode(req_mode), .refuse(refuse)
    );

    assign cur_addr    = q.base + {{(AW-PW){1'b0}}, q.pos};
    assign self_sealed = ((cur_addr >= CODE_LO && cur_addr < CODE_HI) ||
                          cur_addr == GLOCK_A || cur_addr == PLOCK_A) &&
                         is_sealed(stored_i);

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        d.abort = 1'b0;
        d.done  = 1'b0;
        if (!q.busy) begin
            if (req_i) begin
                if (refuse) begin
                    d.abort = 1'b1;
                end else begin
                    d.busy = 1'b1;
                    d.pos  = '0;
                    d.base = {tgt_addr_i[AW-1:PW], {PW{1'b0}}};
                    d.mode = req_mode;
                end
            end
        end else begin
            d.wr_addr = cur_addr;
            d.wr_en   = 1'b1;
            unique case (q.mode)
                MD_OPEN:   d.wr_data = pad_i;
                MD_WRPROT: d.wr_data = stored_i;
                MD_ONEWAY: d.wr_data = stored_i & pad_i;
                MD_REGPG:  d.wr_data = self_sealed ? stored_i : pad_i;
                default: begin
                    d.wr_en   = 1'b0;
                    d.wr_data = stored_i;
                end
            endcase
            d.pos = q.pos + 1'b1;
            if (q.pos == PW'(PG_BYTES - 1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_addr_o = cur_addr;
    assign wr_en_o   = q.wr_en;
    assign wr_addr_o = q.wr_addr;
    assign wr_data_o = q.wr_data;
    assign abort_o   = q.abort;
    assign done_o    = q.done;
    assign busy_o    = q.busy;
endmodule

// File: rtl/eg_checker.sv
module eg_checker #(
    parameter int AW        = 12,
    parameter int PG_BYTES  = 32,
    parameter int BLK_PAGES = 8,
    parameter int NBLK      = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_i,
    input logic          wr_en_o,
    input logic [AW-1:0] wr_addr_o,
    input logic          abort_o,
    input logic          done_o,
    input logic          busy_o
);
    localparam logic [AW-1:0] ROM_LO = AW'(NBLK * BLK_PAGES * PG_BYTES + PG_BYTES);

    // R2
    step_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o && $past(wr_en_o) |-> wr_addr_o == $past(wr_addr_o) + 1'b1);

    // R2
    done_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy_o) && !busy_o);

    // R9
    no_rom_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> wr_addr_o < ROM_LO);

    // R10
    abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> $past(req_i) && !$past(busy_o));

    // R6
    abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> !wr_en_o && !busy_o);
endmodule

bind eeprom_guard eg_checker #(.AW(AW), .PG_BYTES(PG_BYTES), .BLK_PAGES(BLK_PAGES),
                               .NBLK(NBLK)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_en_o(wr_en_o),
    .wr_addr_o(wr_addr_o), .abort_o(abort_o), .done_o(done_o), .busy_o(busy_o)
);

// File: tb/sim_eeprom_guard.sv
`timescale 1ns/1ps
module sim_eeprom_guard;
    logic        clk = 0, rst_n = 0, req = 0;
    logic [11:0] tgt = 0, rd_addr, wr_addr;
    logic [7:0]  stored, padb, wr_data;
    logic        wr_en, abort, done, busy;

    logic [7:0] mem [0:2623];
    logic [7:0] pad [0:31];
    int vectors = 0, misses = 0;

    always #4 clk = ~clk;

    eeprom_guard u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .tgt_addr_i(tgt),
        .rd_addr_o(rd_addr), .stored_i(stored), .pad_i(padb),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .abort_o(abort), .done_o(done), .busy_o(busy)
    );

    assign stored = (rd_addr < 12'hA40) ? mem[rd_addr] : 8'h00;
    assign padb   = pad[rd_addr[4:0]];

    always @(posedge clk) if (wr_en) mem[wr_addr] <= wr_data;

    function automatic bit sealed(input logic [7:0] c);
        return c == 8'h55 || c == 8'hAA;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic set_pad(input int seed);
        for (int k = 0; k < 32; k++) pad[k] = 8'(seed + k * 13);
    endtask

    // Reference: 0 open, 1 stored, 2 AND, 3 register page, 4 no write
    task automatic commit(input int a, input string tag, input bit poke);
        int kind = 0, base;
        bit ab = 0;
        bit          een [32];
        logic [7:0]  edat [32];
        if (a >= 'hA40) ab = 1;
        else if (a >= 'hA20) kind = 4;
        else if (a >= 'hA00) begin
            if (sealed(mem['hA1F])) ab = 1; else kind = 3;
        end else begin
            logic [7:0] c = mem['hA00 + a / 256];
            if (c == 8'h55) begin
                if (sealed(mem['hA1E])) ab = 1; else kind = 1;
            end else if (c == 8'hAA) kind = 2;
        end
        base = a & ~31;
        for (int k = 0; k < 32; k++) begin
            logic [7:0] old;
            int ad = base + k;
            old = (ad < 'hA40) ? mem[ad] : 8'h00;
            een[k] = (kind != 4);
            case (kind)
                0: edat[k] = pad[k];
                1: edat[k] = old;
                2: edat[k] = old & pad[k];
                3: edat[k] = ((ad < 'hA0A || ad >= 'hA1E) && sealed(old)) ? old : pad[k];
                default: edat[k] = old;
            endcase
        end
        @(negedge clk); req = 1; tgt = 12'(a);
        @(negedge clk); req = 0;
        chk(abort == ab, tag, "abort", abort, ab);
        chk(wr_en == 0, tag, "wr_en at accept", wr_en, 0);
        chk(busy == !ab, tag, "busy", busy, !ab);
        if (ab) return;
        for (int k = 0; k < 32; k++) begin
            @(negedge clk);
            req = 0;
            chk(wr_en == een[k], tag, "wr_en", wr_en, een[k]);
            if (een[k]) begin
                chk(wr_addr == 12'(base + k), tag, "wr_addr", wr_addr, base + k);
                chk(wr_data == edat[k], tag, "wr_data", wr_data, edat[k]);
            end
            chk(done == (k == 31), tag, "done", done, k == 31);
            chk(abort == 0, tag, "abort in walk", abort, 0);
            if (poke && k == 3) begin
                req = 1; tgt = 12'h240;   // R12: request while busy
            end
        end
        @(negedge clk);
        chk(wr_en == 0 && busy == 0, tag, "idle after walk", {wr_en, busy}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2560; i++) mem[i] = 8'(i * 37 + 11);
        for (int i = 2560; i < 2592; i++) mem[i] = 8'h00;
        for (int i = 2592; i < 2624; i++) mem[i] = 8'(i ^ 'h5C);
        set_pad('h10);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(wr_en == 0 && abort == 0 && done == 0 && busy == 0, "R1", "reset outputs",
            {wr_en, abort, done, busy}, 0);
        commit('h000, "R1", 0);
        set_pad('h21);
        commit('h125, "R12", 0);        // R12 low bits ignored
        // register page: grp2=55, grp3=AA, grp4=5A
        set_pad('h10);
        pad[2] = 8'h55; pad[3] = 8'hAA; pad[4] = 8'h5A; pad[30] = 8'h00; pad[31] = 8'h00;
        commit('hA00, "R8", 0);
        set_pad('h33);
        commit('h240, "R4", 0);         // R11 new code governs
        commit('h360, "R5", 0);
        commit('h400, "R3", 0);
        // reseal attempt + group lock
        set_pad('h10);
        pad[2] = 8'h00; pad[4] = 8'h55; pad[30] = 8'hAA; pad[31] = 8'h00;
        commit('hA00, "R8", 0);
        chk(mem['hA02] == 8'h55, "R8", "sealed code kept", mem['hA02], 8'h55);
        chk(mem['hA04] == 8'h55, "R8", "open code replaced", mem['hA04], 8'h55);
        set_pad('h47);
        commit('h240, "R6", 0);
        commit('h300, "R6", 0);         // one-way group unaffected
        commit('h400, "R6", 0);
        commit('h100, "R3", 0);
        set_pad('h10);
        pad[31] = 8'h55;
        commit('hA00, "R7", 0);
        commit('hA00, "R7", 0);
        commit('hA20, "R9", 0);
        commit('hA40, "R10", 0);
        commit('hFE0, "R10", 0);
        set_pad('h5B);
        commit('h080, "R12", 1);
        chk(mem['h240] == 8'(('h240) * 37 + 11), "R12", "ignored request left page",
            mem['h240], 8'(('h240) * 37 + 11));
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule